// File: doc/BRIEF.md
# Storage Command Issue Tracker

This block takes block addresses written by a host processor and turns each one into a single command request to a storage controller. That controller can hold a limited number of outstanding commands. The addresses wait in a first-word-fall-through queue. Whenever the queue holds an entry and the controller signals ready, the head entry is presented as a command, and the valid strobe is the queue's pop. Every accepted address is also copied, in the same cycle, to an output port that feeds a companion header queue. That queue is drained more slowly by a data-path block outside this design.

The host reads three values from the block. The first is the free space it may still fill. This value keeps a safety margin so that the slower header queue cannot overflow. The second is the number of commands completed since the current read or write test started. It is computed as the commands issued minus the controller's outstanding count. The third is a sticky flag, raised when the host fails to keep the queue supplied during a running test.

A command strobe marks a new host command. When the strobe is qualified as a read or write command, it starts a test. Any other command kind ends the running test.

Top module: `cq_cmd_issuer`

## Requirements
- R1: After a synchronous active-low reset, the outputs are as follows: `cmd_valid` is 0, `free_space` is 992, `done_count` is 0 and `slow_flag` is 0.
- R2: The address queue holds up to 1024 entries of 48 bits each, in first-in first-out order. While `cmd_valid` is 1, `cmd_addr` is the oldest stored address.
- R3: `cmd_valid` is 1 in exactly those cycles where the queue is non-empty and `cmd_ready` is 1. Each such cycle removes one entry.
- R4: `free_space` equals max(0, 1024 − fill − 32), where fill is the number of stored entries. A write or pop changes fill from the next cycle on.
- R5: A write presented while the queue holds 1024 entries is ignored. It is not stored and it is not mirrored.
- R6: `hdr_wr_en` is 1 in the same cycle as each accepted write, and `hdr_wr_data` then equals `addr_wr_data`.
- R7: `done_count` (45 bits) equals the commands issued since the last read/write start minus `cmd_outstanding`. It is clamped at 0 when that difference would be negative.
- R8: A command strobe with `cmd_rw`=1 resets the issued count to zero. A command issued in that same cycle counts as the first command of the new test.
- R9: `slow_flag` becomes 1 one cycle after any cycle in which all three of these hold: a test is running, at least one command has issued since its start, and the queue is empty. Once set, it stays 1.
- R10: A command strobe with `cmd_rw`=1 clears `slow_flag` from the next cycle on. A strobe with `cmd_rw`=0 ends the running test but leaves the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_wr_en | input | 1 | Host address write strobe |
| addr_wr_data | input | 48 | Block address to enqueue |
| cmd_strobe | input | 1 | New host command this cycle |
| cmd_rw | input | 1 | Strobed command is a read or write test start |
| cmd_ready | input | 1 | Controller can accept a command |
| cmd_outstanding | input | 6 | Commands currently held by the controller (0..32) |
| cmd_valid | output | 1 | Command request, equal to the queue pop |
| cmd_addr | output | 48 | Address of the issued command |
| hdr_wr_en | output | 1 | Mirror write to the header queue |
| hdr_wr_data | output | 48 | Mirrored address |
| free_space | output | 10 | Entries the host may still write |
| done_count | output | 45 | Completed commands since the test started |
| slow_flag | output | 1 | Queue ran dry during a running test |

## Verification
The bench drives a controller model that stalls at random and retires commands at random. It also restarts tests while commands are still outstanding. If the completion clamp were missing, this would make `done_count` wrap to a huge value. The bench fills the queue well past 1024 writes and then drains it. A design that stored or mirrored a write into a full queue would return an address out of order, or would show a spurious `hdr_wr_en`. Free space is checked across the margin boundary at fill 992, where an unclamped subtraction wraps to a large count. The flag tests check three cases. A freshly started test with an empty queue must not flag. A non-read/write command must not clear the flag. A read/write start must clear it even when the queue is empty at that moment.

// File: rtl/cq_pkg.sv
// Shared sizing for the command issue tracker.
// Assumes the queue depth is a power of two.
package cq_pkg;
    localparam int CQ_ADDR_W    = 48;
    localparam int CQ_DEPTH     = 1024;
    localparam int CQ_LAG       = 32;
    localparam int CQ_MAX_OUTST = 32;
    localparam int CQ_DONE_W    = 45;
endpackage

// File: rtl/cq_addr_fifo.sv
// First-word-fall-through address queue.
// The head entry is visible combinationally whenever the queue is non-empty.
// Writes while full are dropped. The caller pops only when non-empty.
// Assumes DEPTH is a power of two, so the pointers wrap naturally.
module cq_addr_fifo #(
    parameter int W     = 48,
    parameter int DEPTH = 1024,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = PW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic          push_ok,
    output logic [W-1:0]  head,
    output logic          empty,
    output logic          full,
    output logic [CW-1:0] fill
);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;
    logic          pop_ok;

    assign empty   = (fill == '0);
    assign full    = (fill == FULL_CNT);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign head    = mem[rd_ptr];

    // Storage write, no reset needed on the array.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_data;
    end

    // Pointer and fill bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (push_ok) wr_ptr <= wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
            case ({push_ok, pop_ok})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end

    AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= FULL_CNT); // R2
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> (fill == FULL_CNT)); // R5
    AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty); // R3
endmodule

// File: rtl/cq_space_calc.sv
// Free-space report: depth minus fill minus a lag margin, clamped at zero.
// The margin lets a slower companion header queue trail the address queue
// without overflowing. Purely combinational.
module cq_space_calc #(
    parameter int DEPTH  = 1024,
    parameter int MARGIN = 32,
    localparam int CW    = $clog2(DEPTH) + 1,
    localparam int OW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] fill,
    output logic [OW-1:0] free_space
);
    localparam logic [CW-1:0] LIMIT = CW'(DEPTH - MARGIN);
    logic [CW-1:0] diff;

    // Clamp the subtraction so that a fill beyond the limit reports zero.
    always_comb begin
        diff       = (fill >= LIMIT) ? '0 : (LIMIT - fill);
        free_space = diff[OW-1:0];
    end

    AST_FREE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        free_space <= OW'(DEPTH - MARGIN)); // R4
    AST_FREE_ZERO_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (fill >= LIMIT) |-> (free_space == '0)); // R4
endmodule

// File: rtl/cq_issue_track.sv
// Test-run tracking: issued-command count, completion count and the
// starvation flag. A read/write start resets the count and clears the flag.
// Another command kind ends the run. The completion count is issued minus
// the controller's outstanding count, clamped at zero.
module cq_issue_track #(
    parameter int DONE_W    = 45,
    parameter int MAX_OUTST = 32,
    localparam int OUTST_W  = $clog2(MAX_OUTST + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               issue,
    input  logic               rw_start,
    input  logic               run_stop,
    input  logic               q_empty,
    input  logic [OUTST_W-1:0] outstanding,
    output logic [DONE_W-1:0]  done_count,
    output logic               slow_flag
);
    logic              running;
    logic [DONE_W-1:0] issued;
    logic [DONE_W-1:0] outst_ext;

    assign outst_ext = DONE_W'(outstanding);

    // Issued count, restarted by each read/write start.
    always_ff @(posedge clk) begin
        if (!rst_n)        issued <= '0;
        else if (rw_start) issued <= DONE_W'(issue);
        else if (issue)    issued <= issued + 1'b1;
    end

    // Run state: entered on a read/write start, left on any other command.
    always_ff @(posedge clk) begin
        if (!rst_n)        running <= 1'b0;
        else if (rw_start) running <= 1'b1;
        else if (run_stop) running <= 1'b0;
    end

    // Sticky starvation flag, armed once the current test has issued.
    always_ff @(posedge clk) begin
        if (!rst_n)        slow_flag <= 1'b0;
        else if (rw_start) slow_flag <= 1'b0;
        else if (running && (issued != '0) && q_empty) slow_flag <= 1'b1;
    end

    // Completions: issued minus still-outstanding, clamped at zero.
    always_comb begin
        done_count = (issued >= outst_ext) ? (issued - outst_ext) : '0;
    end

    AST_SLOW_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        rw_start |=> !slow_flag); // R10
    AST_SLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (slow_flag && !rw_start) |=> slow_flag); // R9
    AST_SLOW_NEEDS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(slow_flag) |-> $past(q_empty)); // R9
    AST_OUTST_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        outstanding <= OUTST_W'(MAX_OUTST)); // R7
endmodule

// File: rtl/cq_cmd_issuer.sv
// Storage command issue tracker top.
// Host addresses enter a first-word-fall-through queue and are mirrored to
// the header queue port. Each pop is one command request, issued when the
// queue is non-empty and the controller is ready. The block reports the
// margined free space, the completion count and the starvation flag.
// Assumes the controller never reports more than MAX_OUTST outstanding.
module cq_cmd_issuer
    import cq_pkg::*;
#(
    parameter int ADDR_W    = CQ_ADDR_W,
    parameter int DEPTH     = CQ_DEPTH,
    parameter int LAG       = CQ_LAG,
    parameter int MAX_OUTST = CQ_MAX_OUTST,
    parameter int DONE_W    = CQ_DONE_W,
    localparam int CW       = $clog2(DEPTH) + 1,
    localparam int FW       = $clog2(DEPTH),
    localparam int OUTST_W  = $clog2(MAX_OUTST + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               addr_wr_en,
    input  logic [ADDR_W-1:0]  addr_wr_data,
    input  logic               cmd_strobe,
    input  logic               cmd_rw,
    input  logic               cmd_ready,
    input  logic [OUTST_W-1:0] cmd_outstanding,
    output logic               cmd_valid,
    output logic [ADDR_W-1:0]  cmd_addr,
    output logic               hdr_wr_en,
    output logic [ADDR_W-1:0]  hdr_wr_data,
    output logic [FW-1:0]      free_space,
    output logic [DONE_W-1:0]  done_count,
    output logic               slow_flag
);
    logic          q_empty;
    logic          q_full;
    logic          q_push_ok;
    logic [CW-1:0] q_fill;
    logic          issue;

    // Issue rule: pop whenever an entry is waiting and the controller is ready.
    assign issue       = !q_empty && cmd_ready;
    assign cmd_valid   = issue;
    assign hdr_wr_en   = q_push_ok;
    assign hdr_wr_data = addr_wr_data;

    cq_addr_fifo #(
        .W     (ADDR_W),
        .DEPTH (DEPTH)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (addr_wr_en),
        .push_data (addr_wr_data),
        .pop       (issue),
        .push_ok   (q_push_ok),
        .head      (cmd_addr),
        .empty     (q_empty),
        .full      (q_full),
        .fill      (q_fill)
    );

    cq_space_calc #(
        .DEPTH  (DEPTH),
        .MARGIN (LAG)
    ) u_space (
        .clk        (clk),
        .rst_n      (rst_n),
        .fill       (q_fill),
        .free_space (free_space)
    );

    cq_issue_track #(
        .DONE_W    (DONE_W),
        .MAX_OUTST (MAX_OUTST)
    ) u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .issue       (issue),
        .rw_start    (cmd_strobe && cmd_rw),
        .run_stop    (cmd_strobe && !cmd_rw),
        .q_empty     (q_empty),
        .outstanding (cmd_outstanding),
        .done_count  (done_count),
        .slow_flag   (slow_flag)
    );

    AST_VALID_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> cmd_ready); // R3
    AST_MIRROR_NOT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_wr_en |-> (addr_wr_en && !q_full)); // R6
endmodule

// File: tb/cq_cmd_issuer_bench.sv
// Cycle-by-cycle reference-model bench for the command issue tracker.
module cq_cmd_issuer_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        addr_wr_en;
    logic [47:0] addr_wr_data;
    logic        cmd_strobe;
    logic        cmd_rw;
    logic        cmd_ready;
    logic [5:0]  cmd_outstanding;
    logic        cmd_valid;
    logic [47:0] cmd_addr;
    logic        hdr_wr_en;
    logic [47:0] hdr_wr_data;
    logic [9:0]  free_space;
    logic [44:0] done_count;
    logic        slow_flag;

    always #(CLK_PERIOD/2) clk = ~clk;

    cq_cmd_issuer u_cq_cmd_issuer (
        .clk(clk), .rst_n(rst_n), .addr_wr_en(addr_wr_en), .addr_wr_data(addr_wr_data),
        .cmd_strobe(cmd_strobe), .cmd_rw(cmd_rw), .cmd_ready(cmd_ready),
        .cmd_outstanding(cmd_outstanding), .cmd_valid(cmd_valid), .cmd_addr(cmd_addr),
        .hdr_wr_en(hdr_wr_en), .hdr_wr_data(hdr_wr_data), .free_space(free_space),
        .done_count(done_count), .slow_flag(slow_flag)
    );

    // Reference model state.
    logic [47:0] mq[$];
    longint      m_issued;
    bit          m_running;
    bit          m_slow;
    int          m_outst;
    int          checks;
    int          failures;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    // One clock: drive at negedge, compare, then advance the model.
    task automatic cycle(input bit wr, input bit rdy, input bit strobe,
                         input bit rw, input bit retire);
        logic [63:0] rnd;
        bit          pop;
        bit          push;
        bit          q_emp;
        longint      e_free;
        longint      e_done;
        @(negedge clk);
        rnd             = {$urandom(), $urandom()};
        addr_wr_en      = wr;
        addr_wr_data    = rnd[47:0];
        cmd_ready       = rdy && (m_outst < 32);
        cmd_strobe      = strobe;
        cmd_rw          = rw;
        cmd_outstanding = 6'(m_outst);
        #1;
        q_emp  = (mq.size() == 0);
        pop    = !q_emp && cmd_ready;
        push   = wr && (mq.size() < 1024);
        e_free = (mq.size() >= 992) ? 0 : 992 - mq.size();
        e_done = (m_issued >= m_outst) ? m_issued - m_outst : 0;
        chk(cmd_valid == pop, "R3", "cmd_valid", longint'(cmd_valid), longint'(pop));
        if (pop) chk(cmd_addr == mq[0], "R2", "cmd_addr", longint'(cmd_addr), longint'(mq[0]));
        chk(hdr_wr_en == push, wr && !push ? "R5" : "R6", "hdr_wr_en",
            longint'(hdr_wr_en), longint'(push));
        if (push) chk(hdr_wr_data == addr_wr_data, "R6", "hdr_wr_data",
                      longint'(hdr_wr_data), longint'(addr_wr_data));
        chk(longint'(free_space) == e_free, "R4", "free_space", longint'(free_space), e_free);
        chk(longint'(done_count) == e_done, "R7", "done_count", longint'(done_count), e_done);
        chk(slow_flag == m_slow, "R9", "slow_flag", longint'(slow_flag), longint'(m_slow));
        // Advance the model to the state after this edge.
        if (strobe && rw)                             m_slow = 1'b0;
        else if (m_running && m_issued != 0 && q_emp) m_slow = 1'b1;
        if (strobe) m_running = rw;
        if (strobe && rw) m_issued = pop ? 1 : 0;
        else if (pop)     m_issued++;
        if (pop)  void'(mq.pop_front());
        if (push) mq.push_back(rnd[47:0]);
        if (retire && m_outst > 0 && ($urandom() % 3 == 0)) m_outst--;
        if (pop) m_outst++;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=1 expected=0");
        summary();
        $finish;
    end

    initial begin
        checks = 0; failures = 0;
        m_issued = 0; m_running = 0; m_slow = 0; m_outst = 0;
        rst_n = 1'b0; addr_wr_en = 0; addr_wr_data = '0; cmd_strobe = 0;
        cmd_rw = 0; cmd_ready = 0; cmd_outstanding = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk(cmd_valid == 1'b0, "R1", "cmd_valid", longint'(cmd_valid), 0);
        chk(free_space == 10'd992, "R1", "free_space", longint'(free_space), 992);
        chk(done_count == '0, "R1", "done_count", longint'(done_count), 0);
        chk(slow_flag == 1'b0, "R1", "slow_flag", longint'(slow_flag), 0);

        // R8/R9: start with an empty queue must not flag before any issue.
        cycle(0, 0, 1, 1, 0);
        repeat (5) cycle(0, 1, 0, 0, 0);
        chk(slow_flag == 1'b0, "R9", "no flag before first issue", longint'(slow_flag), 0);

        // R2/R4: a few writes held, then issued in order.
        repeat (5) cycle(1, 0, 0, 0, 0);
        repeat (8) cycle(0, 1, 0, 0, 1);

        // Random traffic, with restarts while commands are still outstanding (R7/R8).
        for (int i = 0; i < 4000; i++) begin
            bit st;
            bit kind;
            st   = ($urandom() % 300 == 0);
            kind = ($urandom() % 3 != 0);
            cycle(($urandom() % 2) == 0, ($urandom() % 3) != 0, st, kind, 1);
        end

        // Drain the controller, then start a fresh test.
        while (m_outst > 0 || mq.size() > 0) cycle(0, 1, 0, 0, 1);
        cycle(0, 0, 1, 1, 0);

        // R5/R4: overfill the queue with the controller stalled.
        repeat (1040) cycle(1, 0, 0, 0, 0);
        chk(free_space == '0, "R4", "free at full", longint'(free_space), 0);
        chk(hdr_wr_en == 1'b0, "R5", "mirror while full", longint'(hdr_wr_en), 0);
        // Drain in order: a stored dropped write would mismatch cmd_addr (R2/R5).
        while (mq.size() > 0) cycle(0, 1, 0, 0, 1);
        repeat (3) cycle(0, 1, 0, 0, 1);
        chk(slow_flag == 1'b1, "R9", "flag after running dry", longint'(slow_flag), 1);

        // R10: other command kind keeps the flag, a read/write start clears it.
        cycle(0, 0, 1, 0, 1);
        repeat (3) cycle(0, 1, 0, 0, 1);
        chk(slow_flag == 1'b1, "R10", "flag kept by other command", longint'(slow_flag), 1);
        cycle(0, 0, 1, 1, 1);
        cycle(0, 0, 0, 0, 1);
        chk(slow_flag == 1'b0, "R10", "flag cleared by start", longint'(slow_flag), 0);
        while (m_outst > 0) cycle(0, 0, 0, 0, 1);
        cycle(0, 0, 0, 0, 0);
        chk(done_count == 45'(m_issued), "R7", "done after drain",
            longint'(done_count), m_issued);

        summary();
        $finish;
    end
endmodule